// File: doc/BRIEF.md
# Text-Mode Raster Engine

This block turns a screen of character codes into a monochrome 640x480 raster. It runs from one pixel clock of about 25 MHz. It keeps a dot counter and a line counter and produces registered horizontal and vertical sync pulses, both active low. For every character cell it works out where the cell's code is stored and where the current scanline of that glyph is stored. It then serialises the glyph byte onto the three colour lines, which always carry the same bit.

The character store (80 columns by 30 rows, 2400 bytes) and the glyph store (96 glyphs of 8x16 dots, 1536 bytes) sit outside the block. The block reads each of them through a synchronous read port with one cycle of latency: it raises a read strobe with an address, and the data is expected on the following cycle. Every eight dots the block issues three steps in a fixed order. The character read comes first, on counter phase 5. The glyph read follows on phase 6. The shift-register load comes last, on phase 7. The character column is biased by four dots, so the first glyph of a line starts exactly on the first visible dot.

All timing values are parameters. The defaults give 800 dots per line and 525 lines per frame.

Top module: `text_raster`

## Requirements
- R1: The dot counter runs from 0 to 799 and then returns to 0, so each line is 800 clocks long.
- R2: The line counter advances only on the last dot of a line and returns to 0 after line 524.
- R3: hsync_n is low exactly while the dot count is 0 to 95, and high otherwise.
- R4: vsync_n is low exactly during lines 0 and 1, and high otherwise.
- R5: char_rd is high exactly when the low three bits of the dot count equal 5. font_rd is high exactly when they equal 6. The two are never high together.
- R6: On a char_rd cycle at dot counts 141 to 773 of a visible line, char_addr = column + 80 x row. Here column = (dot - 140) / 8 and row = (line - 35) / 16.
- R7: On a font_rd cycle, font_addr = 16 x (bits 6..0 of char_code) + ((line - 35) mod 16). Bit 7 of char_code is ignored.
- R8: Visible pixel p (0 to 639) of line L (35 to 514) appears on the colour outputs during dot count 145 + p. Its value is bit 7 - (p mod 8) of the glyph byte for column p / 8, so the most significant bit comes out first.
- R9: The colour outputs are 0 whenever the dot that produced them lies outside dots 144 to 783 or outside lines 35 to 514. This holds even when the glyph store returns set bits there.
- R10: red, green and blue always carry the same value.
- R11: While rst is high, and in the first cycle after it falls, hsync_n, vsync_n and the colour outputs are 0, and both counters are at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| red | output | 1 | Red colour line |
| green | output | 1 | Green colour line |
| blue | output | 1 | Blue colour line |
| char_rd | output | 1 | Read strobe to the character store |
| char_addr | output | CHAR_AW (12) | Character store address |
| char_code | input | DATA_W (8) | Character store data, one cycle after char_rd |
| font_rd | output | 1 | Read strobe to the glyph store |
| font_addr | output | CODE_W+log2(GLYPH_H) (11) | Glyph store address |
| font_byte | input | 8 | Glyph store data, one cycle after font_rd |

## Verification
Two things share a cycle at each edge of the visible region. The shift register loads the first glyph of a line in the same cycle that horizontal blanking lifts. The last bit of column 79 leaves the register in the same cycle that blanking returns. The bench models both stores so that they return non-zero codes and glyph bytes for the out-of-range addresses fetched in the porches. A gating fault would then show up as a stray lit dot on either side of the 640-dot window. It compares every colour, sync and strobe output against a frame computed arithmetically, cycle by cycle. The vertical timing is shortened to two text rows so that whole frames, including the line and frame wrap, fit in the run.

// File: rtl/text_raster.sv
module text_raster #(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_ACT   = 640,
  parameter int H_FRONT = 16,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33,
  parameter int V_ACT   = 480,
  parameter int V_FRONT = 10,
  parameter int GLYPH_H = 16,
  parameter int CODE_W  = 7,
  parameter int DATA_W  = 8,
  parameter int CHAR_AW = 12,
  localparam int FONT_AW = CODE_W + $clog2(GLYPH_H)
) (
  input  logic               clk,
  input  logic               rst,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               red,
  output logic               green,
  output logic               blue,
  output logic               char_rd,
  output logic [CHAR_AW-1:0] char_addr,
  input  logic [DATA_W-1:0]  char_code,
  output logic               font_rd,
  output logic [FONT_AW-1:0] font_addr,
  input  logic [7:0]         font_byte
);

  localparam int H_TOT   = H_SYNC + H_BACK + H_ACT + H_FRONT;
  localparam int V_TOT   = V_SYNC + V_BACK + V_ACT + V_FRONT;
  localparam int HW      = $clog2(H_TOT);
  localparam int VW      = $clog2(V_TOT);
  localparam int H_START = H_SYNC + H_BACK;
  localparam int H_END   = H_START + H_ACT;
  localparam int V_START = V_SYNC + V_BACK;
  localparam int V_END   = V_START + V_ACT;
  localparam int COLS    = H_ACT / 8;
  localparam int CW      = $clog2(COLS);
  localparam int LW      = $clog2(GLYPH_H);
  localparam int RW      = VW - LW;

  logic [HW-1:0]      hcount;
  logic [VW-1:0]      vcount;
  logic               line_end, frame_end;
  logic               h_vis, v_vis;
  logic               sh_load;
  logic [7:0]         shreg;
  logic               pix;
  logic [HW:0]        col_pos;
  logic [VW-1:0]      line_pos;
  logic [CW-1:0]      column;
  logic [RW-1:0]      row;
  logic [LW-1:0]      scan;
  logic [CHAR_AW-1:0] row_base;

  assign line_end  = (hcount == HW'(H_TOT - 1));
  assign frame_end = (vcount == VW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount <= '0;
      vcount <= '0;
    end else if (line_end) begin
      hcount <= '0;
      vcount <= frame_end ? '0 : vcount + 1'b1;
    end else begin
      hcount <= hcount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              hsync_n <= 1'b0;
    else if (line_end)                    hsync_n <= 1'b0;
    else if (hcount == HW'(H_SYNC - 1))   hsync_n <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) vsync_n <= 1'b0;
    else if (line_end) begin
      if (frame_end)                        vsync_n <= 1'b0;
      else if (vcount == VW'(V_SYNC - 1))   vsync_n <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               h_vis <= 1'b0;
    else if (hcount == HW'(H_START - 1))   h_vis <= 1'b1;
    else if (hcount == HW'(H_END - 1))     h_vis <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) v_vis <= 1'b0;
    else if (line_end) begin
      if (vcount == VW'(V_START - 1))      v_vis <= 1'b1;
      else if (vcount == VW'(V_END - 1))   v_vis <= 1'b0;
    end
  end

  assign char_rd = (hcount[2:0] == 3'd5);
  assign font_rd = (hcount[2:0] == 3'd6);
  assign sh_load = (hcount[2:0] == 3'd7);

  assign col_pos  = {1'b0, hcount} - (HW+1)'(H_START) + (HW+1)'(4);
  assign column   = col_pos[CW+2:3];
  assign line_pos = vcount - VW'(V_START);
  assign row      = line_pos[VW-1:LW];
  assign scan     = line_pos[LW-1:0];

  generate
    if (COLS == 80) begin : g_mul80
      assign row_base = CHAR_AW'({row, 6'd0}) + CHAR_AW'({row, 4'd0});
    end else begin : g_mulgen
      assign row_base = CHAR_AW'(row * COLS);
    end
  endgenerate

  assign char_addr = row_base + CHAR_AW'(column);
  assign font_addr = {char_code[CODE_W-1:0], scan};

  always_ff @(posedge clk) begin
    if (rst)          shreg <= '0;
    else if (sh_load) shreg <= font_byte;
    else              shreg <= {shreg[6:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) pix <= 1'b0;
    else     pix <= shreg[7] & h_vis & v_vis;
  end

  assign red   = pix;
  assign green = pix;
  assign blue  = pix;

  logic [DATA_W-CODE_W+3+HW-CW-3:0] unused_bits;
  assign unused_bits = {char_code[DATA_W-1:CODE_W], col_pos[2:0], col_pos[HW:CW+3]};

endmodule

// File: rtl/text_raster_chk.sv
module text_raster_chk #(
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int H_TOT  = 800,
  parameter int H_SYNC = 96,
  parameter int V_SYNC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic          h_vis,
  input logic          v_vis,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          char_rd,
  input logic          font_rd,
  input logic          sh_load,
  input logic          red,
  input logic          green,
  input logic          blue
);

  AST_HCOUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hcount == HW'(H_TOT - 1)) |=> (hcount == '0));  // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hcount != HW'(H_TOT - 1)) |=> $stable(vcount));  // R2

  AST_HSYNC_SPAN: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n) == (hcount < HW'(H_SYNC)));  // R3

  AST_VSYNC_SPAN: assert property (@(posedge clk) disable iff (rst)
    (!vsync_n) == (vcount < VW'(V_SYNC)));  // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({char_rd, font_rd, sh_load}));  // R5

  AST_PIX_GATED: assert property (@(posedge clk) disable iff (rst)
    red |-> $past(h_vis && v_vis));  // R9

  AST_COLOUR_TIE: assert property (@(posedge clk) disable iff (rst)
    (red == green) && (green == blue));  // R10

endmodule

bind text_raster text_raster_chk #(
  .HW(HW), .VW(VW), .H_TOT(H_TOT), .H_SYNC(H_SYNC), .V_SYNC(V_SYNC)
) u_chk (
  .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
  .h_vis(h_vis), .v_vis(v_vis), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .char_rd(char_rd), .font_rd(font_rd), .sh_load(sh_load),
  .red(red), .green(green), .blue(blue)
);

// File: tb/text_raster_bench.sv
module text_raster_bench;

  localparam int LINES = 40;
  localparam int VST   = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_n, vsync_n, red, green, blue;
  logic        char_rd, font_rd;
  logic [11:0] char_addr;
  logic [10:0] font_addr;
  logic [7:0]  char_code = '0;
  logic [7:0]  font_byte = '0;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  text_raster #(.V_SYNC(2), .V_BACK(3), .V_ACT(32), .V_FRONT(3)) u_text_raster (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue),
    .char_rd(char_rd), .char_addr(char_addr), .char_code(char_code),
    .font_rd(font_rd), .font_addr(font_addr), .font_byte(font_byte)
  );

  function automatic int code_of(int a);
    return ((a * 37 + 11) % 96) | ((a & 1) << 7);
  endfunction

  function automatic int font_of(int fa);
    return (fa * 53 + (fa >> 4) * 17 + 90) & 255;
  endfunction

  always @(posedge clk) begin
    if (char_rd) char_code <= 8'(code_of(int'(char_addr)));
    if (font_rd) font_byte <= 8'(font_of(int'(font_addr)));
  end

  task automatic chk(input string tag, input int t, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  task automatic verify(input int t);
    int h, v, row, ln, a, b, p, e;
    bit act_line;
    h = t % 800;
    v = (t / 800) % LINES;
    act_line = (v >= VST) && (v < VST + 32);
    row = (v - VST) / 16;
    ln  = (v - VST) % 16;
    chk((h == 0 || h == 799) ? "R1 hsync_n at wrap" : "R3 hsync_n", t, int'(hsync_n), int'(h >= 96));
    chk((v == 0 || v == LINES - 1) ? "R2 vsync_n at wrap" : "R4 vsync_n", t, int'(vsync_n), int'(v >= 2));
    chk("R5 char_rd", t, int'(char_rd), int'(h % 8 == 5));
    chk("R5 font_rd", t, int'(font_rd), int'(h % 8 == 6));
    if (act_line && h % 8 == 5 && h >= 141 && h <= 773)
      chk("R6 char_addr", t, int'(char_addr), (h - 140) / 8 + row * 80);
    if (act_line && h % 8 == 6 && h >= 142 && h <= 774) begin
      a = (h - 141) / 8 + row * 80;
      chk("R7 font_addr", t, int'(font_addr), (code_of(a) & 127) * 16 + ln);
    end
    e = 0;
    if (act_line && h >= 145 && h <= 784) begin
      p = h - 145;
      a = p / 8 + row * 80;
      b = font_of((code_of(a) & 127) * 16 + ln);
      e = (b >> (7 - p % 8)) & 1;
      chk("R8 pixel", t, int'(red), e);
    end else begin
      chk("R9 blanked pixel", t, int'(red), 0);
    end
    chk("R10 green", t, int'(green), int'(red));
    chk("R10 blue", t, int'(blue), int'(red));
  endtask

  task automatic reset_state(input int t);
    chk("R11 hsync_n in reset", t, int'(hsync_n), 0);
    chk("R11 vsync_n in reset", t, int'(vsync_n), 0);
    chk("R11 red in reset", t, int'(red), 0);
    chk("R11 char_rd in reset", t, int'(char_rd), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_state(-1);
    rst = 1'b0;
    verify(0);
    for (int i = 1; i <= 2 * LINES * 800 + 100; i++) begin
      @(negedge clk);
      verify(i);
    end
    rst = 1'b1;
    @(negedge clk);
    reset_state(-2);
    rst = 1'b0;
    verify(0);
    for (int i = 1; i <= 1700; i++) begin
      @(negedge clk);
      verify(i);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule